// File: doc/BRIEF.md
# Averaged Signal-Strength Meter with Threshold Interrupt

This block turns the tap outputs of a receive-level detector ladder into one averaged signal-strength figure. The ladder has a number of gain stages, and each stage brings out a full-gain tap and a half-gain tap. Because the taps are thermometer coded, the count of asserted taps gives the level of one sample in 3 dB steps. On each sample strobe the block adds that count to an accumulator. After the last strobe of a fixed window, it scales the window sum into an 8-bit value in 0.5 dB units. With the default parameters there are 11 stages, so 22 taps, and 16 samples per window.

The block compares the result with a programmable threshold. When the RSSI interrupt enable is 1 and the value is at or above the threshold, it sets a sticky signal-detect flag. Software clears the flag by writing one to it. The flag comes back at once if the level is still high enough. A 2-bit routing select decides whether the flag drives the interrupt pin.

Top module: `rssi_avg_irq`

## Requirements
- R1: After reset, `rssi_o` is 0, `sig_det` is 0 and `irq0` is 0.
- R2: The level of a sample is the number of 1 bits in `det_i`, from 0 to 22. Bit position has no effect on it.
- R3: `rssi_o` changes only on the clock edge that takes the 16th strobe of a window. After strobes 1 to 15 it keeps its previous value.
- R4: The new `rssi_o` is floor(S × 3 / 8), where S is the sum of the 16 sample levels. The largest possible value is 132.
- R5: Each window starts from a zero sum. A result depends only on the 16 samples of its own window.
- R6: If `rssi_ie` is 1 and `rssi_o` ≥ `thr` in a cycle, `sig_det` is 1 from the next cycle on. Equality counts as reaching the threshold.
- R7: While `rssi_ie` is 0, a clear flag stays clear whatever the level.
- R8: Once set, `sig_det` stays 1 until a clear, even after the level drops below `thr`.
- R9: A cycle with `det_clr` high clears `sig_det` on the next edge. If the set condition of R6 holds in that same cycle, set wins and the flag stays 1.
- R10: `irq0` equals `sig_det` when `irq0_sel` is 2'b01. For the selects 2'b00, 2'b10 and 2'b11, `irq0` is 0.
- R11: Cycles with `smp_stb` low add nothing to the window and do not advance the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 22 | Detector ladder taps, thermometer coded |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| rssi_ie | input | 1 | RSSI interrupt enable |
| thr | input | 8 | Detect threshold in 0.5 dB units |
| irq0_sel | input | 2 | Routing select for the interrupt pin, 2'b01 routes the flag |
| det_clr | input | 1 | Write-one-to-clear strobe for the flag |
| rssi_o | output | 8 | Averaged strength in 0.5 dB units |
| sig_det | output | 1 | Sticky signal-detect flag |
| irq0 | output | 1 | Interrupt pin level |

## Verification
The collision that matters is a software clear landing in a cycle where the set condition also holds. The bench loads a window that gives exactly the threshold value, lets the flag set, and then pulses `det_clr` with the level unchanged. It expects the flag to still be 1 on the following cycle. It then raises the threshold by one step and pulses `det_clr` again. This time the flag must drop, which shows that the earlier outcome came from set taking priority and not from a clear that had no effect.

// File: rtl/rssi_avg_irq.sv
module rssi_avg_irq #(
  parameter int NSTAGE = 11,
  parameter int NSAMP  = 16,
  parameter int RW     = 8,
  parameter int MUL    = 3,
  parameter int SHR    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NSTAGE-1:0] det_i,
  input  logic                smp_stb,
  input  logic                rssi_ie,
  input  logic [RW-1:0]       thr,
  input  logic [1:0]          irq0_sel,
  input  logic                det_clr,
  output logic [RW-1:0]       rssi_o,
  output logic                sig_det,
  output logic                irq0
);
  localparam int TAPS = 2 * NSTAGE;
  localparam int LW   = $clog2(TAPS + 1);
  localparam int CW   = $clog2(NSAMP);
  localparam int SW   = $clog2(NSAMP * TAPS + 1);
  localparam int PW   = SW + $clog2(MUL + 1);

  logic [LW-1:0] level;
  logic [SW-1:0] acc, acc_nx;
  logic [CW-1:0] cnt;
  logic [PW-1:0] prod;
  logic          last, hit;

  always_comb begin
    level = '0;
    for (int i = 0; i < TAPS; i++) level = level + LW'(det_i[i]);
  end

  assign acc_nx = acc + SW'(level);
  assign last   = smp_stb && (cnt == CW'(NSAMP - 1));
  assign prod   = PW'(acc_nx) * PW'(MUL);
  assign hit    = rssi_ie && (rssi_o >= thr);
  assign irq0   = sig_det && (irq0_sel == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      rssi_o <= '0;
    end else if (smp_stb) begin
      cnt <= last ? '0 : cnt + 1'b1;
      acc <= last ? '0 : acc_nx;
      if (last) rssi_o <= RW'(prod >> SHR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_det <= 1'b0;
    else        sig_det <= hit || (sig_det && !det_clr);
  end
endmodule

module rssi_avg_irq_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          rssi_ie,
  input logic [RW-1:0] thr,
  input logic [1:0]    irq0_sel,
  input logic          det_clr,
  input logic [RW-1:0] rssi_o,
  input logic          sig_det,
  input logic          irq0
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(rssi_o));
  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_o <= RW'(132));
  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_ie && rssi_o >= thr) |=> sig_det);
  assert_noset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rssi_ie && !sig_det) |=> !sig_det);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det && !det_clr) |=> sig_det);
  assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_clr && !(rssi_ie && rssi_o >= thr)) |=> !sig_det);
  assert_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0_sel != 2'b01) |-> !irq0);
  assert_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> sig_det);
endmodule

bind rssi_avg_irq rssi_avg_irq_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rssi_ie(rssi_ie),
  .thr(thr), .irq0_sel(irq0_sel), .det_clr(det_clr), .rssi_o(rssi_o),
  .sig_det(sig_det), .irq0(irq0)
);

// File: tb/tb_rssi_avg_irq.sv
module tb_rssi_avg_irq;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [21:0] det_i = '0;
  logic        smp_stb = 0, rssi_ie = 0, det_clr = 0;
  logic [7:0]  thr = '0;
  logic [1:0]  irq0_sel = 2'b00;
  logic [7:0]  rssi_o;
  logic        sig_det, irq0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  rssi_avg_irq dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] therm(input int l);
    logic [21:0] v = '0;
    for (int i = 0; i < l; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [21:0] scatter(input int l, input int rot);
    logic [21:0] v = '0;
    for (int i = 0; i < l; i++) v[(i * 5 + rot) % 22] = 1'b1;
    return v;
  endfunction

  task automatic strobe(input logic [21:0] v, input int gap);
    @(negedge clk); det_i = v; smp_stb = 1;
    @(negedge clk); smp_stb = 0; det_i = '1;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic window(input int base, input int step, input bit scat,
                        input int gap, input string req);
    int sum = 0;
    int prev;
    prev = rssi_o;
    for (int k = 0; k < 16; k++) begin
      int l = (base + k * step) % 23;
      sum += l;
      strobe(scat ? scatter(l, k) : therm(l), gap);
      if (k == 14) check("R3 hold after 15 strobes", rssi_o, prev);
    end
    check(req, rssi_o, (sum * 3) / 8);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rssi", rssi_o, 0);
    check("R1 flag", sig_det, 0);
    check("R1 irq0", irq0, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 R4 R5: sweep every thermometer level, expected 6*L
    for (int l = 0; l <= 22; l++) window(l, 0, 0, 0, "R4 R5 level sweep");
    check("R4 max", rssi_o, 132);
    // R7: threshold 0 but enable low
    check("R7 no set while disabled", sig_det, 0);
    // R2: scattered bits, mixed levels
    window(3, 7, 1, 0, "R2 scattered bits");
    window(22, 5, 1, 0, "R2 mixed scattered");
    // R11: idle cycles with taps all high between strobes
    window(1, 3, 0, 2, "R11 gaps ignored");
    window(0, 1, 0, 1, "R11 ramp with gaps");
    // R5: new window after a large one
    window(22, 0, 0, 0, "R5 full");
    window(2, 0, 0, 0, "R5 restart");
    check("R7 still clear", sig_det, 0);
    // R6: equality
    window(10, 0, 0, 0, "R4 level 10");
    @(negedge clk); thr = 8'd60; rssi_ie = 1; irq0_sel = 2'b01;
    @(negedge clk);
    check("R6 set at equality", sig_det, 1);
    check("R10 routed", irq0, 1);
    irq0_sel = 2'b00; #1 check("R10 sel 00", irq0, 0);
    irq0_sel = 2'b10; #1 check("R10 sel 10", irq0, 0);
    irq0_sel = 2'b11; #1 check("R10 sel 11", irq0, 0);
    irq0_sel = 2'b01;
    // R9: clear while still at threshold -> set wins
    @(negedge clk); det_clr = 1;
    @(negedge clk); det_clr = 0;
    check("R9 set wins over clear", sig_det, 1);
    // R8: level now below threshold, flag sticky
    thr = 8'd61;
    repeat (3) @(negedge clk);
    check("R8 sticky", sig_det, 1);
    det_clr = 1;
    @(negedge clk); det_clr = 0;
    check("R9 clear below threshold", sig_det, 0);
    check("R10 follows flag", irq0, 0);
    repeat (2) @(negedge clk);
    check("R6 one step below no set", sig_det, 0);
    // R7: disabled with threshold 0
    rssi_ie = 0; thr = 8'd0;
    repeat (3) @(negedge clk);
    check("R7 disabled", sig_det, 0);
    rssi_ie = 1;
    @(negedge clk);
    check("R6 set on enable", sig_det, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule